// File: doc/BRIEF.md
# Scoreboarded Register File with Operand Forwarding

This block is the integer register file of an in-order core that lets memory loads and other long-latency operations finish out of step with issue. Every register carries a busy bit. When a long-latency instruction issues, its destination is marked busy and handed one of a small pool of completion tags. Later instructions whose sources and destination are all free issue at once. An instruction that names a busy register raises a stall until the matching completion arrives.

The file has two combinational operand read ports, addressed by the source fields of the issuing instruction. It has one ALU write port and one completion write port. The completion port carries a tag, and the block looks up the destination register behind that tag. A value being written in the current cycle, from either write port, appears on the operand outputs in that same cycle. The completion also clears its busy bit in that cycle, so a waiting instruction issues on the cycle its data arrives.

Top module: `sb_regfile`

## Requirements
- R1: Synchronous active-low reset clears every register to zero, clears every busy bit and frees every completion tag.
- R2: `stall` is low whenever `iss_valid` is low. An issuing instruction whose enabled sources and destination are all free is not stalled, even while long-latency operations are outstanding.
- R3: An accepted instruction with `iss_long` high marks `iss_rd` busy from the next cycle. In the same cycle it receives on `iss_tag` the lowest-numbered free tag.
- R4: `stall` is high when `iss_valid` is high and an enabled source (`iss_rs1`, `iss_rs2`) is busy, or the destination is busy. The destination counts when `iss_rd_en` or `iss_long` is high.
- R5: A completion with a live tag writes `ret_data` into the register recorded for that tag, clears that busy bit and frees the tag. In the same cycle the data appears on any operand output reading that register, and that register no longer causes a stall.
- R6: An ALU write (`alu_we`) updates `alu_wa`. In the same cycle the written value appears on any operand output addressing that register, and from the next cycle it is read from the file.
- R7: When the completion port and the ALU port target the same register in one cycle, the completion data wins on both the operand outputs and the stored value.
- R8: At most 4 long-latency operations are outstanding (parameter `NTAG`). A long-latency instruction stalls while no tag is free. A freed tag is reused.
- R9: A completion carrying a tag that is not outstanding is ignored: no register, busy bit or tag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An instruction is presented for issue |
| iss_rs1_en | input | 1 | Source 1 is used |
| iss_rs1 | input | 5 | Source 1 register index, also operand read address 1 |
| iss_rs2_en | input | 1 | Source 2 is used |
| iss_rs2 | input | 5 | Source 2 register index, also operand read address 2 |
| iss_rd_en | input | 1 | Instruction writes a destination |
| iss_rd | input | 5 | Destination register index |
| iss_long | input | 1 | Long-latency instruction; its destination is reserved until completion |
| stall | output | 1 | Issue must hold this cycle |
| iss_tag | output | 2 | Tag given to an accepted long-latency instruction |
| alu_we | input | 1 | ALU write enable |
| alu_wa | input | 5 | ALU write register index |
| alu_wd | input | 32 | ALU write data |
| ret_valid | input | 1 | Completion present |
| ret_tag | input | 2 | Tag of the completing operation |
| ret_data | input | 32 | Completion data |
| rd1_data | output | 32 | Operand 1, forwarded where a write hits |
| rd2_data | output | 32 | Operand 2, forwarded where a write hits |

## Verification
The two write paths can land in one cycle, and so can a completion and the issue of an instruction waiting for it. The bench presents both on purpose. It returns data for a busy register while an instruction reading that register is on the issue inputs, and judges that `stall` is low and the operand already carries the returned value. It also drives an ALU write and a completion to the same register together. The operand output must show the completion data in that cycle, and a plain read in the next cycle must show the same data.

// File: rtl/sbrf_pkg.sv
// Package: shared types for the scoreboarded register file.
// Assumes: imported by every sbrf module; holds no widths of its own.
package sbrf_pkg;

    // Origin of the value placed on an operand output.
    typedef enum logic [1:0] {
        SRC_FILE = 2'd0,
        SRC_ALU  = 2'd1,
        SRC_RET  = 2'd2
    } byp_src_e;

    // Completion beats ALU; either beats the stored copy.
    function automatic byp_src_e pick_src(input logic ret_hit, input logic alu_hit);
        if (ret_hit)      return SRC_RET;
        else if (alu_hit) return SRC_ALU;
        else              return SRC_FILE;
    endfunction

endpackage

// File: rtl/sbrf_storage.sv
// Module: sbrf_storage
// Register array with two write ports and NRD combinational read ports.
// Each read port forwards the value being written in the current cycle.
// Assumes: when both write ports name the same register, the completion
// port wins, both in storage and on the forwarded operand.
module sbrf_storage
    import sbrf_pkg::*;
#(
    parameter int NREG = 32,
    parameter int DW   = 32,
    parameter int NRD  = 2,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alu_we,
    input  logic [AW-1:0]            alu_wa,
    input  logic [DW-1:0]            alu_wd,
    input  logic                     ret_we,
    input  logic [AW-1:0]            ret_wa,
    input  logic [DW-1:0]            ret_wd,
    input  logic [NRD-1:0][AW-1:0]   rd_addr,
    output logic [NRD-1:0][DW-1:0]   rd_data
);

    logic [DW-1:0] regs_q [NREG];

    // Update the array; the completion port overrides the ALU port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (ret_we && ret_wa == AW'(i))      regs_q[i] <= ret_wd;
                else if (alu_we && alu_wa == AW'(i)) regs_q[i] <= alu_wd;
            end
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        byp_src_e src;
        // Pick the operand source for this read port.
        always_comb begin
            src = pick_src(ret_we && ret_wa == rd_addr[g],
                           alu_we && alu_wa == rd_addr[g]);
            unique case (src)
                SRC_RET: rd_data[g] = ret_wd;
                SRC_ALU: rd_data[g] = alu_wd;
                default: rd_data[g] = regs_q[rd_addr[g]];
            endcase
        end
    end

endmodule

// File: rtl/sbrf_tagtable.sv
// Module: sbrf_tagtable
// Pool of NTAG completion tags, each holding the destination register of
// one outstanding long-latency operation.
// Assumes: allocation picks a free entry and a live completion names a
// used entry, so both can act in one cycle on different entries.
module sbrf_tagtable #(
    parameter int NREG = 32,
    parameter int NTAG = 4,
    localparam int AW  = $clog2(NREG),
    localparam int TW  = (NTAG > 1) ? $clog2(NTAG) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_fire,
    input  logic [AW-1:0]   alloc_dst,
    output logic            any_free,
    output logic [TW-1:0]   alloc_tag,
    input  logic            ret_valid,
    input  logic [TW-1:0]   ret_tag,
    output logic            ret_live,
    output logic [AW-1:0]   ret_dst,
    output logic [NTAG-1:0] tag_valid
);

    logic [NTAG-1:0] valid_q;
    logic [AW-1:0]   dst_q [NTAG];

    // Lowest-numbered free entry, scanning downwards so the lowest wins.
    always_comb begin
        alloc_tag = '0;
        for (int i = NTAG - 1; i >= 0; i--) begin
            if (!valid_q[i]) alloc_tag = TW'(i);
        end
        any_free = ~&valid_q;
    end

    // Look up the destination behind a returning tag.
    always_comb begin
        ret_live = 1'b0;
        ret_dst  = '0;
        if (int'(ret_tag) < NTAG) begin
            ret_live = ret_valid && valid_q[ret_tag];
            ret_dst  = dst_q[ret_tag];
        end
    end

    // Free completed entries and fill newly allocated ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < NTAG; i++) dst_q[i] <= '0;
        end else begin
            if (ret_live) valid_q[ret_tag] <= 1'b0;
            if (alloc_fire && any_free) begin
                valid_q[alloc_tag] <= 1'b1;
                dst_q[alloc_tag]   <= alloc_dst;
            end
        end
    end

    assign tag_valid = valid_q;

endmodule

// File: rtl/sbrf_scoreboard.sv
// Module: sbrf_scoreboard
// One busy bit per register, plus hazard detection for the issuing
// instruction against those bits.
// Assumes: a clear and a set may hit the same register in one cycle; the
// set wins. A register being cleared this cycle is no longer a hazard.
module sbrf_scoreboard #(
    parameter int NREG = 32,
    parameter int NRD  = 2,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set_en,
    input  logic [AW-1:0]          set_idx,
    input  logic                   clr_en,
    input  logic [AW-1:0]          clr_idx,
    input  logic [NRD-1:0]         src_en,
    input  logic [NRD-1:0][AW-1:0] src_idx,
    input  logic                   dst_en,
    input  logic [AW-1:0]          dst_idx,
    output logic                   hazard,
    output logic [NREG-1:0]        busy
);

    logic [NREG-1:0] busy_q;
    logic [NREG-1:0] clr_mask;
    logic [NREG-1:0] set_mask;
    logic [NREG-1:0] eff_busy;

    // Decode set and clear requests into one-hot masks.
    always_comb begin
        clr_mask = NREG'(clr_en) << clr_idx;
        set_mask = NREG'(set_en) << set_idx;
        eff_busy = busy_q & ~clr_mask;
    end

    // Compare every enabled operand and the destination with the busy bits.
    always_comb begin
        hazard = dst_en && eff_busy[dst_idx];
        for (int i = 0; i < NRD; i++) begin
            if (src_en[i] && eff_busy[src_idx[i]]) hazard = 1'b1;
        end
    end

    // Hold the busy bits; a set is applied after a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= (busy_q & ~clr_mask) | set_mask;
    end

    assign busy = busy_q;

endmodule

// File: rtl/sb_regfile.sv
// Module: sb_regfile (top)
// Register file with per-register busy bits, completion tags for
// long-latency operations, and same-cycle forwarding of both write ports.
// Assumes: the issue stage holds an instruction while stall is high; an
// instruction counts as accepted when iss_valid is high and stall is low.
module sb_regfile
    import sbrf_pkg::*;
#(
    parameter int NREG = 32,
    parameter int DW   = 32,
    parameter int NTAG = 4,
    localparam int AW  = $clog2(NREG),
    localparam int TW  = (NTAG > 1) ? $clog2(NTAG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    input  logic          iss_rs1_en,
    input  logic [AW-1:0] iss_rs1,
    input  logic          iss_rs2_en,
    input  logic [AW-1:0] iss_rs2,
    input  logic          iss_rd_en,
    input  logic [AW-1:0] iss_rd,
    input  logic          iss_long,
    output logic          stall,
    output logic [TW-1:0] iss_tag,
    input  logic          alu_we,
    input  logic [AW-1:0] alu_wa,
    input  logic [DW-1:0] alu_wd,
    input  logic          ret_valid,
    input  logic [TW-1:0] ret_tag,
    input  logic [DW-1:0] ret_data,
    output logic [DW-1:0] rd1_data,
    output logic [DW-1:0] rd2_data
);

    localparam int NRD = 2;

    logic                   any_free;
    logic                   ret_live;
    logic [AW-1:0]          ret_dst;
    logic [NTAG-1:0]        tag_valid;
    logic [NREG-1:0]        busy_vec;
    logic                   hazard;
    logic                   alloc_fire;
    logic [NRD-1:0]         src_en;
    logic [NRD-1:0][AW-1:0] src_idx;
    logic [NRD-1:0][DW-1:0] rd_data;

    // Gather the operand fields into per-port vectors.
    always_comb begin
        src_en  = {iss_rs2_en, iss_rs1_en};
        src_idx = {iss_rs2, iss_rs1};
    end

    // Issue decision: a register hazard, or no tag left for a long op.
    always_comb begin
        stall      = iss_valid && (hazard || (iss_long && !any_free));
        alloc_fire = iss_valid && !stall && iss_long;
    end

    sbrf_tagtable #(.NREG(NREG), .NTAG(NTAG)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_fire (alloc_fire),
        .alloc_dst  (iss_rd),
        .any_free   (any_free),
        .alloc_tag  (iss_tag),
        .ret_valid  (ret_valid),
        .ret_tag    (ret_tag),
        .ret_live   (ret_live),
        .ret_dst    (ret_dst),
        .tag_valid  (tag_valid)
    );

    sbrf_scoreboard #(.NREG(NREG), .NRD(NRD)) u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (alloc_fire),
        .set_idx (iss_rd),
        .clr_en  (ret_live),
        .clr_idx (ret_dst),
        .src_en  (src_en),
        .src_idx (src_idx),
        .dst_en  (iss_rd_en || iss_long),
        .dst_idx (iss_rd),
        .hazard  (hazard),
        .busy    (busy_vec)
    );

    sbrf_storage #(.NREG(NREG), .DW(DW), .NRD(NRD)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .alu_we  (alu_we),
        .alu_wa  (alu_wa),
        .alu_wd  (alu_wd),
        .ret_we  (ret_live),
        .ret_wa  (ret_dst),
        .ret_wd  (ret_data),
        .rd_addr (src_idx),
        .rd_data (rd_data)
    );

    assign rd1_data = rd_data[0];
    assign rd2_data = rd_data[1];

endmodule

// File: rtl/sb_regfile_chk.sv
// Module: sb_regfile_chk
// Checker bound to sb_regfile, watching the issue ports together with the
// busy bits and the tag pool.
// Assumes: connected via the bind below; observes only.
module sb_regfile_chk #(
    parameter int NREG = 32,
    parameter int NTAG = 4,
    localparam int AW  = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            iss_valid,
    input logic            iss_rs1_en,
    input logic [AW-1:0]   iss_rs1,
    input logic [AW-1:0]   iss_rd,
    input logic            stall,
    input logic            alloc_fire,
    input logic            ret_live,
    input logic [AW-1:0]   ret_dst,
    input logic [NREG-1:0] busy_vec,
    input logic [NTAG-1:0] tag_valid
);

    // R2: nothing to issue means no stall.
    assert_idle_no_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid |-> !stall);

    // R3: an accepted long-latency op leaves its destination busy.
    assert_long_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fire |=> busy_vec[$past(iss_rd)]);

    // R4: a busy source not being completed this cycle forces a stall.
    assert_busy_src_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_rs1_en && busy_vec[iss_rs1] && !(ret_live && ret_dst == iss_rs1))
        |-> stall);

    // R5: a live completion frees its register unless it is reserved again.
    assert_ret_clears_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_live && !(alloc_fire && iss_rd == ret_dst)) |=> !busy_vec[$past(ret_dst)]);

    // R8: each busy register is owned by exactly one outstanding tag.
    assert_busy_matches_tags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(busy_vec) == $countones(tag_valid));

endmodule

bind sb_regfile sb_regfile_chk #(.NREG(NREG), .NTAG(NTAG)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_valid  (iss_valid),
    .iss_rs1_en (iss_rs1_en),
    .iss_rs1    (iss_rs1),
    .iss_rd     (iss_rd),
    .stall      (stall),
    .alloc_fire (alloc_fire),
    .ret_live   (ret_live),
    .ret_dst    (ret_dst),
    .busy_vec   (busy_vec),
    .tag_valid  (tag_valid)
);

// File: tb/sb_regfile_tb_top.sv
module sb_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        iss_valid, iss_rs1_en, iss_rs2_en, iss_rd_en, iss_long;
    logic [4:0]  iss_rs1, iss_rs2, iss_rd;
    logic        stall;
    logic [1:0]  iss_tag;
    logic        alu_we;
    logic [4:0]  alu_wa;
    logic [31:0] alu_wd;
    logic        ret_valid;
    logic [1:0]  ret_tag;
    logic [31:0] ret_data;
    logic [31:0] rd1_data, rd2_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sb_regfile dut_i (.*);

    typedef struct packed {
        logic        we;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic [4:0]  a1;
        logic [4:0]  a2;
        logic [31:0] e1;
        logic [31:0] e2;
    } vec_t;

    // R6 vectors: ALU write plus same-cycle reads, applied in order from reset.
    localparam vec_t VEC [6] = '{
        '{1'b1, 5'd5,  32'h1111_1111, 5'd5,  5'd6, 32'h1111_1111, 32'h0},
        '{1'b1, 5'd6,  32'h2222_2222, 5'd5,  5'd6, 32'h1111_1111, 32'h2222_2222},
        '{1'b0, 5'd0,  32'h0,         5'd6,  5'd5, 32'h2222_2222, 32'h1111_1111},
        '{1'b1, 5'd5,  32'h3333_3333, 5'd5,  5'd5, 32'h3333_3333, 32'h3333_3333},
        '{1'b1, 5'd31, 32'hDEAD_BEEF, 5'd31, 5'd0, 32'hDEAD_BEEF, 32'h0},
        '{1'b0, 5'd0,  32'h0,         5'd31, 5'd5, 32'hDEAD_BEEF, 32'h3333_3333}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        iss_valid = 0; iss_rs1_en = 0; iss_rs2_en = 0; iss_rd_en = 0; iss_long = 0;
        iss_rs1 = 0; iss_rs2 = 0; iss_rd = 0;
        alu_we = 0; alu_wa = 0; alu_wd = 0;
        ret_valid = 0; ret_tag = 0; ret_data = 0;
    endtask

    // Move to the next falling edge (one rising edge passes), then drive.
    task automatic next();
        @(negedge clk);
        idle();
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic long_op(input logic [4:0] rd);
        iss_valid = 1; iss_long = 1; iss_rd = rd;
    endtask

    initial begin
        do_reset();
        idle();

        // R1: registers read zero after reset, nothing stalls.
        iss_rs1 = 5'd5; iss_rs2 = 5'd31;
        settle();
        check("R1 r5 after reset", rd1_data, 32'h0);
        check("R1 r31 after reset", rd2_data, 32'h0);
        check("R2 stall with no issue", {31'b0, stall}, 32'h0);

        // R6: vector walk.
        foreach (VEC[i]) begin
            next();
            alu_we = VEC[i].we; alu_wa = VEC[i].wa; alu_wd = VEC[i].wd;
            iss_rs1 = VEC[i].a1; iss_rs2 = VEC[i].a2;
            settle();
            check("R6 operand 1", rd1_data, VEC[i].e1);
            check("R6 operand 2", rd2_data, VEC[i].e2);
        end

        // R3: first long op to r7 gets tag 0.
        next(); long_op(5'd7); settle();
        check("R2 long op not stalled", {31'b0, stall}, 32'h0);
        check("R3 first tag", {30'b0, iss_tag}, 32'd0);

        // R4: source r7 busy.
        next(); iss_valid = 1; iss_rs1_en = 1; iss_rs1 = 5'd7; settle();
        check("R4 busy source stalls", {31'b0, stall}, 32'h1);

        // R2: independent instruction proceeds.
        next(); iss_valid = 1; iss_rs1_en = 1; iss_rs1 = 5'd5; iss_rd_en = 1; iss_rd = 5'd6; settle();
        check("R2 independent issue", {31'b0, stall}, 32'h0);

        // R4: destination r7 busy.
        next(); iss_valid = 1; iss_rd_en = 1; iss_rd = 5'd7; settle();
        check("R4 busy destination stalls", {31'b0, stall}, 32'h1);

        // R3: tags handed out in order.
        next(); long_op(5'd8);  settle(); check("R3 second tag", {30'b0, iss_tag}, 32'd1);
        next(); long_op(5'd9);  settle(); check("R3 third tag",  {30'b0, iss_tag}, 32'd2);
        next(); long_op(5'd10); settle(); check("R3 fourth tag", {30'b0, iss_tag}, 32'd3);

        // R8: pool exhausted.
        next(); long_op(5'd11); settle();
        check("R8 no free tag stalls", {31'b0, stall}, 32'h1);

        // R5: completion and waiting reader in the same cycle.
        next(); iss_valid = 1; iss_rs1_en = 1; iss_rs1 = 5'd7;
        ret_valid = 1; ret_tag = 2'd0; ret_data = 32'h0000_0077; settle();
        check("R5 waiting reader released", {31'b0, stall}, 32'h0);
        check("R5 completion forwarded", rd1_data, 32'h0000_0077);

        next(); iss_valid = 1; iss_rs1_en = 1; iss_rs1 = 5'd7; settle();
        check("R5 stored completion", rd1_data, 32'h0000_0077);
        check("R5 register free", {31'b0, stall}, 32'h0);

        // R7: completion and ALU hit r8 together.
        next(); ret_valid = 1; ret_tag = 2'd1; ret_data = 32'hAAAA_0001;
        alu_we = 1; alu_wa = 5'd8; alu_wd = 32'hBBBB_0002; iss_rs1 = 5'd8; settle();
        check("R7 forwarded winner", rd1_data, 32'hAAAA_0001);
        next(); iss_rs1 = 5'd8; settle();
        check("R7 stored winner", rd1_data, 32'hAAAA_0001);

        // R9: tag 0 is idle now; completion ignored.
        next(); ret_valid = 1; ret_tag = 2'd0; ret_data = 32'h0000_0099; iss_rs1 = 5'd7; settle();
        check("R9 idle tag not forwarded", rd1_data, 32'h0000_0077);
        next(); iss_rs1 = 5'd7; settle();
        check("R9 idle tag not stored", rd1_data, 32'h0000_0077);

        // R8: freed tags reused, lowest first.
        next(); long_op(5'd11); settle();
        check("R8 long op after free", {31'b0, stall}, 32'h0);
        check("R8 reused tag", {30'b0, iss_tag}, 32'd0);

        // R1: reset drops busy bits and contents.
        next(); do_reset(); idle();
        iss_valid = 1; iss_rs1_en = 1; iss_rs1 = 5'd9; settle();
        check("R1 busy cleared by reset", {31'b0, stall}, 32'h0);
        iss_rs1 = 5'd5; settle();
        check("R1 contents cleared by reset", rd1_data, 32'h0);

        next();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule